// File: doc/BRIEF.md
# PLL lock monitor with memory-clock fallback switch

This block sits between a phase-locked loop and the clock input of an on-chip memory controller. While the loop has not yet reported lock, the memory controller is fed a safe clock made by dividing the loop output by eight. As soon as lock is reported, the feed moves to the full-rate loop output. When lock is lost, it moves back. Each change of source goes through a handshake that never shortens a high or low phase of the output clock.

The block also offers an 8-bit read-only status word on a simple memory-mapped bus. The word shows the synchronized lock level and a live, synchronized copy of the crystal input. It also holds a sticky loss-of-lock flag, which is cleared by writing 1 to it and drives an interrupt line. The loop, the oscillators and the lock detector are not part of the block; they reach it as plain inputs.

Top module: `lksw_top`

## Requirements
- R1: While the lock input is low, `mem_clk` runs at the `pll_clk` frequency divided by 8.
- R2: While the lock input is high, `mem_clk` runs at the full `pll_clk` frequency.
- R3: No high phase and no low phase of `mem_clk` is shorter than half a `pll_clk` period, including across a source change.
- R4: Status bit 1 shows the lock input. It passes through two `clk` flops and follows a change at the second rising `clk` edge after that change.
- R5: Status bit 2 is a live copy of `xtal_in`, synchronized the same way as bit 1, with the same two-edge delay.
- R6: Status bit 0, the loss-of-lock flag, is set on the third rising `clk` edge after the lock input falls. `lock_irq` always equals bit 0.
- R7: A bus write to the status address with `bus_wdata[0]`=1 clears bit 0 at that edge. Writes with `bus_wdata[0]`=0 have no effect, and `bus_wdata[7:1]` have no effect in any write.
- R8: If a loss-of-lock event and a clearing write happen in the same cycle, the flag is set.
- R9: The status word is at address 0xFFFF0400, and its bits 7 to 3 read as 0. A read at any other address returns 0, and a write to any other address changes nothing.
- R10: While `rst` is high, the status word reads 0, `lock_irq` is 0 and `mem_clk` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_clk | input | 1 | Loop output clock |
| pll_lock_in | input | 1 | Asynchronous lock indicator from the loop |
| xtal_in | input | 1 | Asynchronous crystal input level |
| bus_addr | input | 32 | Bus address |
| bus_wr | input | 1 | Write strobe, one `clk` cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| lock_irq | output | 1 | Loss-of-lock interrupt, equal to status bit 0 |
| mem_clk | output | 1 | Clock for the memory controller |

## Verification
The bench changes the asynchronous inputs at a falling `clk` edge and reads the status word at the falling edge after each rising edge. It checks that the lock and crystal bits are still old after the first rising edge and new after the second. It checks that the flag is still clear after the second edge and set after the third. A clearing write takes effect at the same edge it is sampled, and for the same-cycle conflict the write is timed to land exactly on the third edge. The clock rate is checked only after 40 `pll_clk` cycles of settling, by counting `mem_clk` edges over a 64-cycle window with a tolerance of one edge. A monitor that times every phase of `mem_clk` runs for the whole run and covers every switch.

// File: rtl/lksw_pkg.sv
`timescale 1ns/1ps
package lksw_pkg;

    localparam logic [31:0] STATUS_ADDR = 32'hFFFF_0400;
    localparam int          BUS_DW      = 8;
    localparam int          SYNC_STAGES = 2;
    localparam int          DIV_LOG2    = 3;

    // Write-one-to-clear mask: only the flag bit is writable.
    localparam logic [BUS_DW-1:0] W1C_MASK = 8'h01;

    typedef struct packed {
        logic [4:0] rsvd;
        logic       xtal;
        logic       lock;
        logic       lost;
    } status_t;

    function automatic logic [BUS_DW-1:0] pack_status(input logic lock_lvl,
                                                      input logic xtal_lvl,
                                                      input logic lost_flag);
        status_t s;
        s.rsvd = '0;
        s.xtal = xtal_lvl;
        s.lock = lock_lvl;
        s.lost = lost_flag;
        return s;
    endfunction

    function automatic logic addr_hit(input logic [31:0] a);
        return a == STATUS_ADDR;
    endfunction

endpackage

// File: rtl/lksw_sync.sv
`timescale 1ns/1ps
module lksw_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= '0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lksw_clkdiv.sv
`timescale 1ns/1ps
module lksw_clkdiv #(
    parameter int DIV_LOG2 = 3
) (
    input  logic pll_clk,
    input  logic rst,
    output logic clk_div
);
    localparam int CW = (DIV_LOG2 < 1) ? 1 : DIV_LOG2;

    logic [CW-1:0] cnt;

    always_ff @(posedge pll_clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    // MSB of a free-running counter: 50 % duty at 1/2^DIV_LOG2 of the input rate
    assign clk_div = cnt[CW-1];
endmodule

// File: rtl/lksw_clksel.sv
`timescale 1ns/1ps
module lksw_clksel (
    input  logic pll_clk,
    input  logic clk_div,
    input  logic rst,
    input  logic sel_full,
    output logic mem_clk
);
    logic full_m, full_en;
    logic div_m,  div_en;

    // All enables move on the falling edge of pll_clk, while pll_clk is low.
    always_ff @(negedge pll_clk) begin
        if (rst) begin
            full_m  <= 1'b0;
            full_en <= 1'b0;
            div_m   <= 1'b0;
            div_en  <= 1'b0;
        end else begin
            full_m  <= sel_full & ~div_en & ~div_m;
            full_en <= full_m;
            div_m   <= ~sel_full & ~full_en & ~full_m;
            // the divided path's enable only moves while clk_div is low
            if (!clk_div) div_en <= div_m;
        end
    end

    assign mem_clk = (pll_clk & full_en) | (clk_div & div_en);

    AST_EN_EXCLUSIVE: assert property (@(negedge pll_clk) disable iff (rst)
        !(full_en && div_en)) else $error("both clock paths enabled"); // R3

    AST_DIV_EN_LOW_PHASE: assert property (@(negedge pll_clk) disable iff (rst)
        !$stable(div_en) |-> !$past(clk_div)) else $error("divided enable moved while high"); // R3

    AST_FULL_NEEDS_HANDSHAKE: assert property (@(negedge pll_clk) disable iff (rst)
        $rose(full_en) |-> !$past(div_en)) else $error("full enable rose without release"); // R2
endmodule

// File: rtl/lksw_status.sv
`timescale 1ns/1ps
module lksw_status
    import lksw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lock_s,
    input  logic              xtal_s,
    input  logic [31:0]       bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              lost_flag
);
    logic lock_prev;
    logic fall;
    logic clr;
    logic hit;

    assign hit  = addr_hit(bus_addr);
    assign fall = lock_prev & ~lock_s;
    assign clr  = bus_wr & hit & ((bus_wdata & W1C_MASK) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_prev <= 1'b0;
            lost_flag <= 1'b0;
        end else begin
            lock_prev <= lock_s;
            if (fall)     lost_flag <= 1'b1;   // set wins over clear
            else if (clr) lost_flag <= 1'b0;
        end
    end

    assign bus_rdata = hit ? pack_status(lock_s, xtal_s, lost_flag) : '0;

    AST_FALL_SETS: assert property (@(posedge clk) disable iff (rst)
        fall |=> lost_flag) else $error("fall did not set flag"); // R6

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (fall && clr) |=> lost_flag) else $error("clear won over set"); // R8

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
        (clr && !fall) |=> !lost_flag) else $error("clear failed"); // R7

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr && !fall) |=> $stable(lost_flag)) else $error("flag moved by itself"); // R7

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[7:3] == 5'd0) else $error("reserved bits nonzero"); // R9
endmodule

// File: rtl/lksw_top.sv
`timescale 1ns/1ps
module lksw_top
    import lksw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pll_clk,
    input  logic              pll_lock_in,
    input  logic              xtal_in,
    input  logic [31:0]       bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              lock_irq,
    output logic              mem_clk
);
    logic [1:0] bus_sync_q;
    logic       sel_full;
    logic       clk_div;
    logic       lost_flag;

    // bus-domain copies of the asynchronous levels: {xtal, lock}
    lksw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_bus_sync (
        .clk (clk),
        .rst (rst),
        .d   ({xtal_in, pll_lock_in}),
        .q   (bus_sync_q)
    );

    // loop-domain copy of lock for the clock switch
    lksw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_pll_sync (
        .clk (pll_clk),
        .rst (rst),
        .d   (pll_lock_in),
        .q   (sel_full)
    );

    lksw_clkdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
        .pll_clk (pll_clk),
        .rst     (rst),
        .clk_div (clk_div)
    );

    lksw_clksel u_sel (
        .pll_clk  (pll_clk),
        .clk_div  (clk_div),
        .rst      (rst),
        .sel_full (sel_full),
        .mem_clk  (mem_clk)
    );

    lksw_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .lock_s    (bus_sync_q[0]),
        .xtal_s    (bus_sync_q[1]),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lost_flag (lost_flag)
    );

    assign lock_irq = lost_flag;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (lock_irq == 1'b0)) else $error("irq during reset"); // R10
endmodule

// File: tb/lksw_top_test.sv
`timescale 1ns/1ps
module lksw_top_test;
    localparam logic [31:0] ADDR  = 32'hFFFF_0400;
    localparam logic [31:0] OTHER = 32'hFFFF_0404;
    localparam real PLL_HALF = 3.0;

    // {lock, xtal, wr, wdata[7:0], expected status[7:0]}
    localparam int NV = 10;
    localparam logic [18:0] VECS [NV] = '{
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h00},
        {1'b1, 1'b0, 1'b0, 8'h00, 8'h02},
        {1'b1, 1'b1, 1'b0, 8'h00, 8'h06},
        {1'b0, 1'b1, 1'b0, 8'h00, 8'h05},
        {1'b0, 1'b0, 1'b1, 8'hFE, 8'h01},
        {1'b0, 1'b0, 1'b1, 8'h01, 8'h00},
        {1'b1, 1'b1, 1'b0, 8'h00, 8'h06},
        {1'b1, 1'b0, 1'b1, 8'hFF, 8'h02},
        {1'b0, 1'b0, 1'b0, 8'h00, 8'h01},
        {1'b0, 1'b1, 1'b1, 8'h01, 8'h04}
    };

    logic        clk = 1'b0;
    logic        pll_clk = 1'b0;
    logic        rst = 1'b1;
    logic        pll_lock_in = 1'b0;
    logic        xtal_in = 1'b0;
    logic [31:0] bus_addr = ADDR;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        lock_irq;
    logic        mem_clk;

    int  n_checks = 0;
    int  n_errors = 0;
    int  rises = 0;
    real t_rise = -1.0, t_fall = -1.0, min_phase = 1.0e9;
    bit  done = 0;

    always #2 clk = ~clk;          // 250 MHz
    always #3 pll_clk = ~pll_clk;  // loop output

    lksw_top uut (
        .clk(clk), .rst(rst), .pll_clk(pll_clk), .pll_lock_in(pll_lock_in),
        .xtal_in(xtal_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_irq(lock_irq),
        .mem_clk(mem_clk)
    );

    // phase-width monitor for mem_clk (R3)
    always @(posedge mem_clk) begin
        rises++;
        if (!rst && t_fall >= 0.0 && ($realtime - t_fall) < min_phase) min_phase = $realtime - t_fall;
        t_rise = $realtime;
    end
    always @(negedge mem_clk) begin
        if (!rst && t_rise >= 0.0 && ($realtime - t_rise) < min_phase) min_phase = $realtime - t_rise;
        t_fall = $realtime;
    end

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write(input logic [31:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0; bus_addr = ADDR; bus_wdata = 8'h00;
    endtask

    task automatic count_edges(output int n);
        int start;
        repeat (40) @(posedge pll_clk);
        #1;
        start = rises;
        repeat (64) @(posedge pll_clk);
        #1;
        n = rises - start;
    endtask

    task automatic check_rate(input string req, input int exp);
        int n;
        count_edges(n);
        n_checks++;
        if (n < exp - 1 || n > exp + 1) begin
            n_errors++;
            $display("FAIL %s: got %0d mem_clk edges expected %0d", req, n, exp);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (10) @(negedge clk);
        check("R10 status in reset", bus_rdata, 8'h00);
        check("R10 irq in reset", lock_irq, 0);
        check("R10 mem_clk held", mem_clk, 0);
        pll_lock_in = 1'b1; xtal_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 status ignores inputs in reset", bus_rdata, 8'h00);
        pll_lock_in = 1'b0; xtal_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();

        // table walk: R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            pll_lock_in = VECS[i][18];
            xtal_in     = VECS[i][17];
            repeat (4) tick();
            if (VECS[i][16]) write(ADDR, VECS[i][15:8]);
            tick();
            check($sformatf("R4/R5/R7 vector %0d status", i), bus_rdata, VECS[i][7:0]);
            check($sformatf("R6 vector %0d irq", i), lock_irq, VECS[i][0]);
        end

        // R4 R5: two-edge latency
        pll_lock_in = 1'b0; xtal_in = 1'b0;
        repeat (4) tick();
        write(ADDR, 8'h01);
        pll_lock_in = 1'b1; xtal_in = 1'b1;
        tick();
        check("R4 lock bit after 1 edge", bus_rdata[1], 0);
        check("R5 xtal bit after 1 edge", bus_rdata[2], 0);
        tick();
        check("R4 lock bit after 2 edges", bus_rdata[1], 1);
        check("R5 xtal bit after 2 edges", bus_rdata[2], 1);

        // R6: flag on the third edge after the fall
        repeat (3) tick();
        pll_lock_in = 1'b0;
        tick(); tick();
        check("R6 flag after 2 edges", bus_rdata[0], 0);
        tick();
        check("R6 flag after 3 edges", bus_rdata[0], 1);
        check("R6 irq follows flag", lock_irq, 1);

        // R9: other address
        write(OTHER, 8'hFF);
        check("R9 write elsewhere ignored", lock_irq, 1);
        bus_addr = OTHER;
        #1;
        check("R9 read elsewhere is zero", bus_rdata, 8'h00);
        bus_addr = ADDR;
        write(ADDR, 8'h01);
        check("R7 clear", lock_irq, 0);

        // R8: set and clear in the same cycle
        pll_lock_in = 1'b1;
        repeat (4) tick();
        pll_lock_in = 1'b0;
        tick(); tick();
        write(ADDR, 8'h01);
        check("R8 set beats clear", bus_rdata[0], 1);
        tick();
        check("R8 flag stays set", lock_irq, 1);
        write(ADDR, 8'h01);

        // R1 R2: clock rates across switches
        pll_lock_in = 1'b0;
        check_rate("R1 divided rate", 8);
        pll_lock_in = 1'b1;
        check_rate("R2 full rate", 64);
        pll_lock_in = 1'b0;
        check_rate("R1 divided rate after loss", 8);
        pll_lock_in = 1'b1;
        check_rate("R2 full rate after relock", 64);
        pll_lock_in = 1'b0;
        repeat (60) @(posedge pll_clk);

        // R3: shortest phase seen
        n_checks++;
        if (min_phase < PLL_HALF - 0.01) begin
            n_errors++;
            $display("FAIL R3: got min phase %0.3f ns expected >= %0.3f ns", min_phase, PLL_HALF);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule